// File: doc/BRIEF.md
# Inverter Leg Switching Timing Guard

This block sits between a PWM generator and the gate-command pins of a three-leg bridge with a brake switch. Each leg has two active-high requests, one for the upper switch and one for the lower switch. The block turns these requests into active-low drive commands that follow three timing rules. It puts an off gap of at least a set number of cycles between one switch of a leg turning off and the other turning on. It keeps every upper ON pulse at least a minimum length. It cuts off any upper or lower ON pulse that runs past a maximum length. All timing values are parameters counted in clock cycles. At the default settings with a 100 MHz clock they give a 4 us off gap, a 2 us minimum upper pulse and a 500 us maximum pulse, which suits carrier frequencies up to 15 kHz.

Each leg has its own state machine. The states are IDLE (both off, free to turn on), ARM (an upper request is being qualified; used only in suppress mode), UP_ON and LO_ON (a switch is driven), UP_HOLD (an upper pulse is held on to reach the minimum), DEAD (the off gap is running) and LOCK_UP / LOCK_LO (a pulse was cut at the maximum; the switch stays off until its request is released). The transitions are: IDLE to ARM, UP_ON or LO_ON on a single-sided request. ARM to UP_ON once the request has been held for the minimum. ARM to IDLE when the request ends early. UP_ON to UP_HOLD when the request ends early. UP_ON or UP_HOLD to DEAD once the minimum has been met. LO_ON to DEAD on release. UP_ON or LO_ON to the matching LOCK state at the maximum. A LOCK state goes to DEAD on release. DEAD goes to IDLE, ARM, UP_ON or LO_ON at the end of the off gap.

A request that arrives while DEAD is running is remembered and served when the gap ends. A later request for the other switch replaces it. The brake switch is passed through as a registered, inverted copy of its request, with no pulse limits.

Top module: `inverter_timing_guard`

## Requirements
- R1: While rst_n is low, every drive output is high (off) and short_flag and maxon_viol are 0, whatever the requests are.
- R2: A request is active high. A leg whose upper request alone is 1 (lower 0) drives up_drv_n low, and one whose lower request alone is 1 drives lo_drv_n low. The drive goes low in the cycle after the first clock edge that samples the request. In suppress mode the upper drive is additionally delayed as R8 states.
- R3: When both requests of a leg are 1 together, neither switch of that leg is driven. The two drive outputs of a leg are never low in the same cycle.
- R4: After one switch of a leg turns off, the other stays off for at least DEAD_CYC cycles. If its request is first sampled G cycles after the turn-off, the off gap is exactly max(G, DEAD_CYC).
- R5: A request that is sampled during the off gap is remembered and served when the gap ends, even if it was released before then. In that case the drive lasts one cycle.
- R6: If both switches are requested one after the other during the same off gap, the later request replaces the earlier one. Only the later switch is driven.
- R7: Stretch mode (SUPPRESS_SHORT=0): an upper request shorter than MIN_ON_CYC is held on for exactly MIN_ON_CYC cycles, and short_flag pulses high for one cycle.
- R8: Suppress mode (SUPPRESS_SHORT=1): an upper request held for fewer than MIN_ON_CYC cycles is never driven, and short_flag pulses high for one cycle. A request held W ≥ MIN_ON_CYC cycles is driven starting MIN_ON_CYC−1 cycles later than in stretch mode. It lasts max(W−MIN_ON_CYC+1, MIN_ON_CYC) cycles, capped at MAX_ON_CYC.
- R9: The lower switch has no minimum. A lower request of W cycles gives exactly W drive cycles (up to the maximum) and never pulses short_flag.
- R10: An upper or lower request held longer than MAX_ON_CYC cycles is driven for exactly MAX_ON_CYC cycles. The switch then stays off until the request is released, and maxon_viol for that leg goes to 1 and stays 1 until reset. A request of exactly MAX_ON_CYC cycles does not set it.
- R11: brk_drv_n is the inverse of brk_req delayed by one clock. It has no minimum or maximum pulse limit and never sets maxon_viol.
- R12: Each leg has its own guard. Identical requests on two legs give identical drives and flags on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | N_PHASE | Upper-switch ON request, one bit per leg |
| lo_req | input | N_PHASE | Lower-switch ON request, one bit per leg |
| brk_req | input | 1 | Brake-switch ON request |
| up_drv_n | output | N_PHASE | Upper-switch drive command, active low |
| lo_drv_n | output | N_PHASE | Lower-switch drive command, active low |
| brk_drv_n | output | 1 | Brake-switch drive command, active low |
| short_flag | output | N_PHASE | One-cycle pulse when an upper request is shorter than the minimum |
| maxon_viol | output | N_PHASE | Sticky flag: a pulse on that leg was cut at the maximum |

## Verification
The timing properties assume the parameters are ordered so that 1 ≤ DEAD_CYC, 1 ≤ MIN_ON_CYC < MAX_ON_CYC. Under that assumption any request pattern must give non-overlapping drives, off gaps of at least DEAD_CYC, upper pulses of at least MIN_ON_CYC and no pulse longer than MAX_ON_CYC. The brake check assumes brk_req is held low while rst_n is low, and the stimulus always does this. The stimulus uses small values (off gap 4, minimum 3, maximum 12). It sweeps single-sided pulse widths from 1 cycle to past the maximum on a stretch-mode and a suppress-mode instance. It sweeps the gap between an upper release and a lower request across the off-gap window in both directions, and adds the remembered, replaced and conflicting request cases. Every request returns to idle long enough for the leg to reach IDLE before the next trial.

// File: rtl/inv_guard_pkg.sv
package inv_guard_pkg;

    typedef enum logic [1:0] {
        SIDE_NONE,
        SIDE_UP,
        SIDE_LO
    } side_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_UP_ON,
        ST_UP_HOLD,
        ST_LO_ON,
        ST_DEAD,
        ST_LOCK_UP,
        ST_LOCK_LO
    } leg_state_e;

    // A leg asks for one switch only when exactly one request bit is set.
    function automatic side_e decode_side(input logic up, input logic lo);
        if (up && !lo) begin
            return SIDE_UP;
        end else if (lo && !up) begin
            return SIDE_LO;
        end
        return SIDE_NONE;
    endfunction

endpackage

// File: rtl/leg_guard.sv
module leg_guard
    import inv_guard_pkg::*;
#(
    parameter int unsigned DEAD_CYC       = 400,
    parameter int unsigned MIN_ON_CYC     = 200,
    parameter int unsigned MAX_ON_CYC     = 50000,
    parameter bit          SUPPRESS_SHORT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_req,
    input  logic lo_req,
    output logic up_drv_n,
    output logic lo_drv_n,
    output logic short_pulse,
    output logic maxon_sticky
);

    localparam int unsigned LIMIT_A = (MAX_ON_CYC > DEAD_CYC) ? MAX_ON_CYC : DEAD_CYC;
    localparam int unsigned LIMIT   = (LIMIT_A > MIN_ON_CYC) ? LIMIT_A : MIN_ON_CYC;
    localparam int unsigned CNT_W   = $clog2(LIMIT + 1);
    localparam bit          USE_ARM = SUPPRESS_SHORT && (MIN_ON_CYC > 1);
    localparam bit          FLAG_ON_STRETCH = !SUPPRESS_SHORT;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] DEAD_L  = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_ON_CYC);
    localparam logic [CNT_W-1:0] MIN_M1  = CNT_W'(MIN_ON_CYC - 1);
    localparam logic [CNT_W-1:0] MAX_L   = CNT_W'(MAX_ON_CYC);

    leg_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    side_e            pend, pend_nxt;
    side_e            side;
    side_e            tgt;
    logic             short_ev, viol_ev;
    logic             short_q, viol_q;

    function automatic leg_state_e enter_state(input side_e t);
        case (t)
            SIDE_UP: return USE_ARM ? ST_ARM : ST_UP_ON;
            SIDE_LO: return ST_LO_ON;
            default: return ST_IDLE;
        endcase
    endfunction

    assign side = decode_side(up_req, lo_req);
    assign tgt  = (side != SIDE_NONE) ? side : pend;

    // Next-state and event logic
    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt;
        pend_nxt = pend;
        short_ev = 1'b0;
        viol_ev  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (side != SIDE_NONE) begin
                    st_nxt   = enter_state(side);
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = SIDE_NONE;
                end
            end
            ST_ARM: begin
                if (side == SIDE_UP) begin
                    if (cnt == MIN_M1) begin
                        st_nxt  = ST_UP_ON;
                        cnt_nxt = CNT_ONE;
                    end else begin
                        cnt_nxt = cnt + CNT_ONE;
                    end
                end else begin
                    st_nxt   = ST_IDLE;
                    short_ev = 1'b1;
                end
            end
            ST_UP_ON: begin
                if (side == SIDE_UP) begin
                    if (cnt == MAX_L) begin
                        st_nxt  = ST_LOCK_UP;
                        viol_ev = 1'b1;
                    end else begin
                        cnt_nxt = cnt + CNT_ONE;
                    end
                end else if (cnt >= MIN_L) begin
                    st_nxt   = ST_DEAD;
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = side;
                end else begin
                    st_nxt   = ST_UP_HOLD;
                    cnt_nxt  = cnt + CNT_ONE;
                    pend_nxt = side;
                    short_ev = FLAG_ON_STRETCH;
                end
            end
            ST_UP_HOLD: begin
                if (side != SIDE_NONE) begin
                    pend_nxt = side;
                end
                if (cnt >= MIN_L) begin
                    st_nxt  = ST_DEAD;
                    cnt_nxt = CNT_ONE;
                end else begin
                    cnt_nxt = cnt + CNT_ONE;
                end
            end
            ST_LO_ON: begin
                if (side == SIDE_LO) begin
                    if (cnt == MAX_L) begin
                        st_nxt  = ST_LOCK_LO;
                        viol_ev = 1'b1;
                    end else begin
                        cnt_nxt = cnt + CNT_ONE;
                    end
                end else begin
                    st_nxt   = ST_DEAD;
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = side;
                end
            end
            ST_DEAD: begin
                if (cnt >= DEAD_L) begin
                    st_nxt   = enter_state(tgt);
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = SIDE_NONE;
                end else begin
                    cnt_nxt = cnt + CNT_ONE;
                    if (side != SIDE_NONE) begin
                        pend_nxt = side;
                    end
                end
            end
            ST_LOCK_UP: begin
                if (side != SIDE_UP) begin
                    st_nxt   = ST_DEAD;
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = side;
                end
            end
            ST_LOCK_LO: begin
                if (side != SIDE_LO) begin
                    st_nxt   = ST_DEAD;
                    cnt_nxt  = CNT_ONE;
                    pend_nxt = side;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            pend    <= SIDE_NONE;
            short_q <= 1'b0;
            viol_q  <= 1'b0;
        end else begin
            st      <= st_nxt;
            cnt     <= cnt_nxt;
            pend    <= pend_nxt;
            short_q <= short_ev;
            viol_q  <= viol_q | viol_ev;
        end
    end

    // Output decode
    always_comb begin
        up_drv_n = 1'b1;
        lo_drv_n = 1'b1;
        unique case (st)
            ST_UP_ON, ST_UP_HOLD: up_drv_n = 1'b0;
            ST_LO_ON:             lo_drv_n = 1'b0;
            default: begin
                up_drv_n = 1'b1;
                lo_drv_n = 1'b1;
            end
        endcase
        short_pulse  = short_q;
        maxon_sticky = viol_q;
    end

endmodule

// File: rtl/brake_path.sv
module brake_path (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_req,
    output logic brk_drv_n
);

    logic brk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b1;
        end else begin
            brk_q <= ~brk_req;
        end
    end

    assign brk_drv_n = brk_q;

endmodule

// File: rtl/inverter_timing_guard.sv
module inverter_timing_guard #(
    parameter int unsigned N_PHASE        = 3,
    parameter int unsigned DEAD_CYC       = 400,
    parameter int unsigned MIN_ON_CYC     = 200,
    parameter int unsigned MAX_ON_CYC     = 50000,
    parameter bit          SUPPRESS_SHORT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] up_req,
    input  logic [N_PHASE-1:0] lo_req,
    input  logic               brk_req,
    output logic [N_PHASE-1:0] up_drv_n,
    output logic [N_PHASE-1:0] lo_drv_n,
    output logic               brk_drv_n,
    output logic [N_PHASE-1:0] short_flag,
    output logic [N_PHASE-1:0] maxon_viol
);

    for (genvar i = 0; i < N_PHASE; i++) begin : g_phase
        leg_guard #(
            .DEAD_CYC      (DEAD_CYC),
            .MIN_ON_CYC    (MIN_ON_CYC),
            .MAX_ON_CYC    (MAX_ON_CYC),
            .SUPPRESS_SHORT(SUPPRESS_SHORT)
        ) u_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .up_req      (up_req[i]),
            .lo_req      (lo_req[i]),
            .up_drv_n    (up_drv_n[i]),
            .lo_drv_n    (lo_drv_n[i]),
            .short_pulse (short_flag[i]),
            .maxon_sticky(maxon_viol[i])
        );
    end

    brake_path u_brake (
        .clk      (clk),
        .rst_n    (rst_n),
        .brk_req  (brk_req),
        .brk_drv_n(brk_drv_n)
    );

endmodule

module inverter_timing_guard_chk #(
    parameter int unsigned N_PHASE    = 3,
    parameter int unsigned DEAD_CYC   = 400,
    parameter int unsigned MIN_ON_CYC = 200,
    parameter int unsigned MAX_ON_CYC = 50000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_PHASE-1:0] up_drv_n,
    input logic [N_PHASE-1:0] lo_drv_n,
    input logic               brk_req,
    input logic               brk_drv_n,
    input logic [N_PHASE-1:0] maxon_viol
);

    for (genvar i = 0; i < N_PHASE; i++) begin : g_chk
        int unsigned up_on_run, lo_on_run, up_off_run, lo_off_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                up_on_run  <= 0;
                lo_on_run  <= 0;
                up_off_run <= DEAD_CYC;
                lo_off_run <= DEAD_CYC;
            end else begin
                up_on_run  <= !up_drv_n[i] ? up_on_run + 1 : 0;
                lo_on_run  <= !lo_drv_n[i] ? lo_on_run + 1 : 0;
                up_off_run <= !up_drv_n[i] ? 0 : ((up_off_run < DEAD_CYC) ? up_off_run + 1 : up_off_run);
                lo_off_run <= !lo_drv_n[i] ? 0 : ((lo_off_run < DEAD_CYC) ? lo_off_run + 1 : lo_off_run);
            end
        end

        assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(!up_drv_n[i] && !lo_drv_n[i]));

        assert_up_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(up_drv_n[i]) |-> (lo_off_run >= DEAD_CYC));

        assert_lo_dead_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lo_drv_n[i]) |-> (up_off_run >= DEAD_CYC));

        assert_up_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(up_drv_n[i]) |-> (up_on_run >= MIN_ON_CYC));

        assert_up_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !up_drv_n[i] |-> (up_on_run < MAX_ON_CYC));

        assert_lo_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !lo_drv_n[i] |-> (lo_on_run < MAX_ON_CYC));

        assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            maxon_viol[i] |=> maxon_viol[i]);
    end

    assert_brake_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (brk_drv_n == !$past(brk_req)));

endmodule

bind inverter_timing_guard inverter_timing_guard_chk #(
    .N_PHASE   (N_PHASE),
    .DEAD_CYC  (DEAD_CYC),
    .MIN_ON_CYC(MIN_ON_CYC),
    .MAX_ON_CYC(MAX_ON_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_drv_n  (up_drv_n),
    .lo_drv_n  (lo_drv_n),
    .brk_req   (brk_req),
    .brk_drv_n (brk_drv_n),
    .maxon_viol(maxon_viol)
);

// File: tb/inverter_timing_guard_tb.sv
module inverter_timing_guard_tb;

    localparam int NP   = 2;
    localparam int DEAD = 4;
    localparam int MINW = 3;
    localparam int MAXW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] up_req = '0;
    logic [NP-1:0] lo_req = '0;
    logic          brk_req = 1'b0;
    logic [NP-1:0] up_n_a, lo_n_a, sf_a, mv_a;
    logic [NP-1:0] up_n_b, lo_n_b, sf_b, mv_b;
    logic          brk_n_a, brk_n_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    inverter_timing_guard #(
        .N_PHASE(NP), .DEAD_CYC(DEAD), .MIN_ON_CYC(MINW), .MAX_ON_CYC(MAXW), .SUPPRESS_SHORT(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .lo_req(lo_req), .brk_req(brk_req),
        .up_drv_n(up_n_a), .lo_drv_n(lo_n_a), .brk_drv_n(brk_n_a),
        .short_flag(sf_a), .maxon_viol(mv_a)
    );

    inverter_timing_guard #(
        .N_PHASE(NP), .DEAD_CYC(DEAD), .MIN_ON_CYC(MINW), .MAX_ON_CYC(MAXW), .SUPPRESS_SHORT(1'b1)
    ) u_dut_sup (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .lo_req(lo_req), .brk_req(brk_req),
        .up_drv_n(up_n_b), .lo_drv_n(lo_n_b), .brk_drv_n(brk_n_b),
        .short_flag(sf_b), .maxon_viol(mv_b)
    );

    // Per-trial observations; index 0 = stretch instance, 1 = suppress instance
    int tcyc;
    int up_cnt[2], up_first[2], up_last[2];
    int lo_cnt[2], lo_first[2], lo_last[2];
    int short_cnt[2], viol_last[2];
    int brk_cnt, brk_first, mism;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            tcyc++;
            for (int d = 0; d < 2; d++) begin
                logic [NP-1:0] u, l, s, v;
                u = (d == 0) ? up_n_a : up_n_b;
                l = (d == 0) ? lo_n_a : lo_n_b;
                s = (d == 0) ? sf_a : sf_b;
                v = (d == 0) ? mv_a : mv_b;
                if (!u[0]) begin
                    up_cnt[d]++;
                    if (up_first[d] < 0) up_first[d] = tcyc;
                    up_last[d] = tcyc;
                end
                if (!l[0]) begin
                    lo_cnt[d]++;
                    if (lo_first[d] < 0) lo_first[d] = tcyc;
                    lo_last[d] = tcyc;
                end
                if (s[0]) short_cnt[d]++;
                viol_last[d] = int'(v[0]);
                if (u[0] != u[1] || l[0] != l[1] || s[0] != s[1] || v[0] != v[1]) mism++;
            end
            if (!brk_n_a) begin
                brk_cnt++;
                if (brk_first < 0) brk_first = tcyc;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic begin_trial();
        rst_n   = 1'b0;
        up_req  = '0;
        lo_req  = '0;
        brk_req = 1'b0;
        repeat (2) @(negedge clk);
        tcyc = 0; brk_cnt = 0; brk_first = -1;
        for (int d = 0; d < 2; d++) begin
            up_cnt[d] = 0; up_first[d] = -1; up_last[d] = -1;
            lo_cnt[d] = 0; lo_first[d] = -1; lo_last[d] = -1;
            short_cnt[d] = 0; viol_last[d] = 0;
        end
        rst_n = 1'b1;
    endtask

    task automatic step(input logic u, input logic l, input logic b);
        up_req  = {NP{u}};
        lo_req  = {NP{l}};
        brk_req = b;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0);
    endtask

    localparam int SETTLE = MAXW + DEAD + MINW + 8;

    initial begin
        int exp_w, wr;

        // R1: reset holds everything off even with requests asserted
        rst_n = 1'b0;
        up_req = '1; lo_req = '0; brk_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "up_drv_n during reset", int'(up_n_a), (1 << NP) - 1);
        check("R1", "lo_drv_n during reset", int'(lo_n_b), (1 << NP) - 1);
        check("R1", "brk_drv_n during reset", int'(brk_n_a), 1);
        check("R1", "flags during reset", int'({sf_a, mv_a, sf_b, mv_b}), 0);

        // R2 R7 R8 R10: upper width sweep on both instances
        for (int w = 1; w <= MAXW + MINW + 1; w++) begin
            begin_trial();
            for (int k = 0; k < w; k++) step(1'b1, 1'b0, 1'b0);
            idle(SETTLE);
            exp_w = (w < MINW) ? MINW : ((w > MAXW) ? MAXW : w);
            check("R7", $sformatf("stretch up width w=%0d", w), up_cnt[0], exp_w);
            check("R2", $sformatf("stretch up start w=%0d", w), up_first[0], 1);
            check("R7", $sformatf("stretch short flag w=%0d", w), short_cnt[0], (w < MINW) ? 1 : 0);
            check("R10", $sformatf("stretch viol w=%0d", w), viol_last[0], (w > MAXW) ? 1 : 0);
            if (w < MINW) begin
                check("R8", $sformatf("suppress up width w=%0d", w), up_cnt[1], 0);
                check("R8", $sformatf("suppress short flag w=%0d", w), short_cnt[1], 1);
                check("R8", $sformatf("suppress viol w=%0d", w), viol_last[1], 0);
            end else begin
                wr = w - MINW + 1;
                exp_w = (wr < MINW) ? MINW : ((wr > MAXW) ? MAXW : wr);
                check("R8", $sformatf("suppress up width w=%0d", w), up_cnt[1], exp_w);
                check("R8", $sformatf("suppress up start w=%0d", w), up_first[1], MINW);
                check("R8", $sformatf("suppress short flag w=%0d", w), short_cnt[1], 0);
                check("R10", $sformatf("suppress viol w=%0d", w), viol_last[1], (wr > MAXW) ? 1 : 0);
            end
        end

        // R9 R10: lower width sweep
        for (int w = 1; w <= MAXW + 2; w++) begin
            begin_trial();
            for (int k = 0; k < w; k++) step(1'b0, 1'b1, 1'b0);
            idle(SETTLE);
            for (int d = 0; d < 2; d++) begin
                check("R9", $sformatf("lo width d=%0d w=%0d", d, w), lo_cnt[d], (w > MAXW) ? MAXW : w);
                check("R2", $sformatf("lo start d=%0d w=%0d", d, w), lo_first[d], 1);
                check("R9", $sformatf("lo short flag d=%0d w=%0d", d, w), short_cnt[d], 0);
                check("R10", $sformatf("lo viol d=%0d w=%0d", d, w), viol_last[d], (w > MAXW) ? 1 : 0);
            end
        end

        // R4: upper-to-lower gap sweep (stretch instance)
        for (int g = 0; g <= DEAD + 2; g++) begin
            begin_trial();
            for (int k = 0; k < MINW + 1; k++) step(1'b1, 1'b0, 1'b0);
            idle(g);
            for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 1'b0);
            idle(SETTLE);
            check("R4", $sformatf("up->lo gap g=%0d", g), lo_first[0] - up_last[0] - 1, (g > DEAD) ? g : DEAD);
            check("R4", $sformatf("up->lo lo width g=%0d", g), lo_cnt[0], 7 - ((DEAD > g) ? DEAD - g : 0));
        end

        // R4: lower-to-upper gap sweep (stretch instance)
        for (int g = 0; g <= DEAD + 2; g++) begin
            begin_trial();
            for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0);
            idle(g);
            for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0);
            idle(SETTLE);
            check("R4", $sformatf("lo->up gap g=%0d", g), up_first[0] - lo_last[0] - 1, (g > DEAD) ? g : DEAD);
        end

        // R5: one-cycle lower request inside the off gap is served later
        begin_trial();
        for (int k = 0; k < MINW + 1; k++) step(1'b1, 1'b0, 1'b0);
        idle(1);
        step(1'b0, 1'b1, 1'b0);
        idle(SETTLE);
        check("R5", "remembered lo width", lo_cnt[0], 1);
        check("R5", "remembered lo gap", lo_first[0] - up_last[0] - 1, DEAD);

        // R6: later upper request replaces earlier lower request
        begin_trial();
        for (int k = 0; k < MINW + 1; k++) step(1'b1, 1'b0, 1'b0);
        idle(1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        idle(SETTLE);
        check("R6", "replaced lo never driven", lo_cnt[0], 0);
        check("R6", "up total cycles", up_cnt[0], (MINW + 1) + MINW);
        check("R6", "short flag for served pulse", short_cnt[0], 1);

        // R3: both requests together drive nothing
        begin_trial();
        for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0);
        idle(SETTLE);
        for (int d = 0; d < 2; d++) begin
            check("R3", $sformatf("both-request up d=%0d", d), up_cnt[d], 0);
            check("R3", $sformatf("both-request lo d=%0d", d), lo_cnt[d], 0);
        end

        // R11: brake has no limits
        begin_trial();
        for (int k = 0; k < 3 * MAXW; k++) step(1'b0, 1'b0, 1'b1);
        idle(4);
        check("R11", "brake width", brk_cnt, 3 * MAXW);
        check("R11", "brake start", brk_first, 1);
        check("R11", "brake viol", viol_last[0], 0);
        check("R11", "brake matches on both", int'(brk_n_a ^ brk_n_b), 0);

        // R12: both legs behaved identically throughout
        check("R12", "leg mismatch cycles", mism, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule